// File: doc/BRIEF.md
# Display Adapter Register Window Decoder

This block sits behind a 4 KiB memory-mapped register aperture of a display adapter. It accepts one bus request at a time and decodes its address. It then sends the access to one of three regions.

The first region is a relocated copy of the legacy byte-wide port space. Every byte of an access reaches the legacy register file as a separate byte operation, and multi-byte accesses go out lowest byte first. The second region holds an indexed bank of 16-bit extension registers. Each access loads the bank's index register and then does the data transfer. The third region is a small block of 32-bit words. It reports its own size and holds a framebuffer byte-order flag, which changes only when one of two exact 32-bit patterns is written.

The bus side uses a valid/ready handshake. `req_size` is 0 for a byte, 1 for a 16-bit access and 2 for a 32-bit access. Write data is right-aligned in `req_wdata`. Every accepted request, read or write, returns exactly one `rsp_valid` pulse. Read data is right-aligned in `rsp_rdata`, and writes return zero.

Top module: `mmio_win`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid`, `leg_stb` and `ext_stb` are 0, `big_endian_fb` is 0 (little-endian), and `rev_id` is 2 when the word region is enabled and 1 when it is not.
- R2: An access of N bytes (N = 1, 2, 4) whose bytes all lie in offsets 0x400..0x41F produces N legacy operations on N consecutive cycles. Operation k (k = 0 first) uses port 0x3C0 + (addr - 0x400) + k, and on a write it carries `req_wdata` bits 8k+7:8k, so the low (index) byte always goes first.
- R3: A legacy read returns the byte of operation k in `rsp_rdata` bits 8k+7:8k, with the upper bits zero. The response appears N+1 cycles after acceptance.
- R4: An access whose address lies in 0x500..0x515, of any size, first drives `ext_stb` with `ext_idx_load`=1 and `ext_wdata` = (addr - 0x500) >> 1. On the next cycle it drives `ext_stb` with `ext_idx_load`=0 and does the data transfer: a write sends `req_wdata[15:0]`, and a read returns `ext_rdata` zero-extended. The response appears 3 cycles after acceptance.
- R5: A 32-bit read of 0x600 returns 8, the size of the word region in bytes.
- R6: A 32-bit read of 0x604 returns 0xBEBEBEBE when `big_endian_fb` is 1 and 0x1E1E1E1E when it is 0. A 32-bit write of 0xBEBEBEBE there sets the flag, a write of 0x1E1E1E1E clears it, and any other value leaves it unchanged.
- R7: In the word region (0x600..0x607), byte and 16-bit accesses, and 32-bit reads at other offsets, return 0 and do not change the flag.
- R8: An access that falls outside every region returns 0 one cycle after acceptance and causes no legacy or extension operation. This includes a legacy access that runs past 0x41F, an address at 0x516 or above, a `req_size` of 3, and any access to 0x600..0x607 when the word region is disabled. `req_ready` stays high through such an access.
- R9: Word-region accesses complete one cycle after acceptance, and no legacy or extension operation takes place.
- R10: `req_ready` is 0 on every cycle in which a legacy or extension operation is in progress, so exactly one response follows each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the aperture |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 invalid |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Right-aligned read data, 0 for writes |
| leg_stb | output | 1 | Legacy byte operation this cycle |
| leg_we | output | 1 | Legacy operation is a write |
| leg_port | output | 10 | Legacy port number |
| leg_wdata | output | 8 | Legacy write byte |
| leg_rdata | input | 8 | Legacy read byte, valid in the strobe cycle |
| ext_stb | output | 1 | Extension bank operation this cycle |
| ext_idx_load | output | 1 | 1 = index register load, 0 = data transfer |
| ext_we | output | 1 | Extension operation is a write |
| ext_wdata | output | 16 | Index value or write data |
| ext_rdata | input | 16 | Data of the indexed register, valid in the strobe cycle |
| big_endian_fb | output | 1 | Framebuffer byte-order flag |
| rev_id | output | 8 | Adapter revision: 2 with the word region, 1 without |

## Verification
The legacy region is swept over every offset with every access size. This separates accesses that fit from those that straddle the end of the region, and it shows wrong byte order or wrong port numbering, because each write carries a pattern that differs per byte. The extension bank is written at every index with distinct values and read back at both the even and the odd address of each register. A missing or wrong index load therefore shows up as a mismatch. The byte-order register gets both magic values, near-miss values and non-32-bit accesses. A second instance with the word region disabled tells an enabled region apart from a disabled one.

// File: rtl/mmio_win_pkg.sv
package mmio_win_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_LEG  = 2'd1,
        RGN_EXT  = 2'd2,
        RGN_XA   = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEG  = 2'd1,
        ST_EIDX = 2'd2,
        ST_EDAT = 2'd3
    } state_e;

    localparam logic [31:0] MAGIC_BIG    = 32'hBEBE_BEBE;
    localparam logic [31:0] MAGIC_LITTLE = 32'h1E1E_1E1E;

endpackage

// File: rtl/mmio_win_decode.sv
module mmio_win_decode
    import mmio_win_pkg::*;
#(
    parameter int          AW       = 12,
    parameter int unsigned LEG_BASE = 32'h400,
    parameter int unsigned LEG_SPAN = 32'h20,
    parameter int unsigned EXT_BASE = 32'h500,
    parameter int unsigned EXT_REGS = 11,
    parameter int unsigned XA_BASE  = 32'h600,
    parameter int unsigned XA_SPAN  = 8,
    parameter bit          XA_ON    = 1'b1
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output region_e       rgn,
    output logic [AW-1:0] off,
    output logic [2:0]    nbytes
);
    localparam int unsigned EXT_SPAN = 2 * EXT_REGS;

    logic [31:0] a;
    logic [31:0] n;

    always_comb begin
        a      = 32'(addr);
        nbytes = 3'd1;
        case (size)
            2'd1:    nbytes = 3'd2;
            2'd2:    nbytes = 3'd4;
            default: nbytes = 3'd1;
        endcase
        n   = 32'(nbytes);
        rgn = RGN_NONE;
        off = '0;
        if (size == 2'd3) begin
            rgn = RGN_NONE;
        end else if (a >= LEG_BASE && (a + n) <= (LEG_BASE + LEG_SPAN)) begin
            rgn = RGN_LEG;
            off = AW'(a - LEG_BASE);
        end else if (a >= EXT_BASE && a < (EXT_BASE + EXT_SPAN)) begin
            rgn = RGN_EXT;
            off = AW'(a - EXT_BASE);
        end else if (XA_ON && a >= XA_BASE && a < (XA_BASE + XA_SPAN)) begin
            rgn = RGN_XA;
            off = AW'(a - XA_BASE);
        end
    end

endmodule

// File: rtl/mmio_win_xreg.sv
module mmio_win_xreg
    import mmio_win_pkg::*;
#(
    parameter int unsigned XA_SPAN = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc,
    input  logic        we,
    input  logic        word,
    input  logic [2:0]  off,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        big_q
);
    logic big_d;

    always_comb begin
        big_d = big_q;
        if (acc && we && word && off == 3'd4) begin
            if (wdata == MAGIC_BIG) begin
                big_d = 1'b1;
            end else if (wdata == MAGIC_LITTLE) begin
                big_d = 1'b0;
            end
        end
        rdata = '0;
        if (word) begin
            case (off)
                3'd0:    rdata = 32'(XA_SPAN);
                3'd4:    rdata = big_q ? MAGIC_BIG : MAGIC_LITTLE;
                default: rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            big_q <= 1'b0;
        end else begin
            big_q <= big_d;
        end
    end

endmodule

// File: rtl/mmio_win.sv
module mmio_win
    import mmio_win_pkg::*;
#(
    parameter int          AW        = 12,
    parameter int          PORT_W    = 10,
    parameter int unsigned LEG_BASE  = 32'h400,
    parameter int unsigned LEG_SPAN  = 32'h20,
    parameter int unsigned LEG_PORT0 = 32'h3C0,
    parameter int unsigned EXT_BASE  = 32'h500,
    parameter int unsigned EXT_REGS  = 11,
    parameter int unsigned XA_BASE   = 32'h600,
    parameter int unsigned XA_SPAN   = 8,
    parameter bit          XA_ON     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              leg_stb,
    output logic              leg_we,
    output logic [PORT_W-1:0] leg_port,
    output logic [7:0]        leg_wdata,
    input  logic [7:0]        leg_rdata,
    output logic              ext_stb,
    output logic              ext_idx_load,
    output logic              ext_we,
    output logic [15:0]       ext_wdata,
    input  logic [15:0]       ext_rdata,
    output logic              big_endian_fb,
    output logic [7:0]        rev_id
);
    localparam logic [7:0] REV = XA_ON ? 8'd2 : 8'd1;

    typedef struct packed {
        state_e        state;
        logic [1:0]    cnt;
        logic [1:0]    last;
        logic          we;
        logic [AW-1:0] off;
        logic [31:0]   wdata;
        logic [31:0]   acc;
        logic          rsp_v;
        logic [31:0]   rsp_d;
    } st_t;

    st_t st_d, st_q;

    region_e       rgn;
    logic [AW-1:0] dec_off;
    logic [2:0]    nbytes;
    logic          idle;
    logic          xa_acc;
    logic [31:0]   xa_rdata;

    mmio_win_decode #(
        .AW(AW), .LEG_BASE(LEG_BASE), .LEG_SPAN(LEG_SPAN),
        .EXT_BASE(EXT_BASE), .EXT_REGS(EXT_REGS),
        .XA_BASE(XA_BASE), .XA_SPAN(XA_SPAN), .XA_ON(XA_ON)
    ) u_dec (
        .addr(req_addr), .size(req_size),
        .rgn(rgn), .off(dec_off), .nbytes(nbytes)
    );

    assign idle   = (st_q.state == ST_IDLE);
    assign xa_acc = idle && req_valid && (rgn == RGN_XA);

    mmio_win_xreg #(.XA_SPAN(XA_SPAN)) u_xreg (
        .clk(clk), .rst_n(rst_n), .acc(xa_acc), .we(req_we),
        .word(req_size == 2'd2), .off(3'(dec_off)), .wdata(req_wdata),
        .rdata(xa_rdata), .big_q(big_endian_fb)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.we    = req_we;
                    st_d.off   = dec_off;
                    st_d.wdata = req_wdata;
                    st_d.acc   = '0;
                    st_d.cnt   = '0;
                    st_d.last  = 2'(nbytes - 3'd1);
                    case (rgn)
                        RGN_LEG: st_d.state = ST_LEG;
                        RGN_EXT: st_d.state = ST_EIDX;
                        RGN_XA: begin
                            st_d.rsp_v = 1'b1;
                            st_d.rsp_d = req_we ? '0 : xa_rdata;
                        end
                        default: begin
                            st_d.rsp_v = 1'b1;
                            st_d.rsp_d = '0;
                        end
                    endcase
                end
            end
            ST_LEG: begin
                if (!st_q.we) begin
                    st_d.acc = st_q.acc | (32'(leg_rdata) << {st_q.cnt, 3'b000});
                end
                if (st_q.cnt == st_q.last) begin
                    st_d.state = ST_IDLE;
                    st_d.rsp_v = 1'b1;
                    st_d.rsp_d = st_q.we ? '0 : st_d.acc;
                end else begin
                    st_d.cnt = st_q.cnt + 2'd1;
                end
            end
            ST_EIDX: begin
                st_d.state = ST_EDAT;
            end
            default: begin
                st_d.state = ST_IDLE;
                st_d.rsp_v = 1'b1;
                st_d.rsp_d = st_q.we ? '0 : 32'(ext_rdata);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready    = idle;
    assign rsp_valid    = st_q.rsp_v;
    assign rsp_rdata    = st_q.rsp_d;
    assign leg_stb      = (st_q.state == ST_LEG);
    assign leg_we       = st_q.we;
    assign leg_port     = PORT_W'(LEG_PORT0) + PORT_W'(st_q.off) + PORT_W'(st_q.cnt);
    assign leg_wdata    = 8'(st_q.wdata >> {st_q.cnt, 3'b000});
    assign ext_stb      = (st_q.state == ST_EIDX) || (st_q.state == ST_EDAT);
    assign ext_idx_load = (st_q.state == ST_EIDX);
    assign ext_we       = ext_idx_load ? 1'b1 : st_q.we;
    assign ext_wdata    = ext_idx_load ? 16'(st_q.off >> 1) : st_q.wdata[15:0];
    assign rev_id       = REV;

endmodule

// File: rtl/mmio_win_chk.sv
module mmio_win_chk
    import mmio_win_pkg::*;
#(
    parameter int          AW      = 12,
    parameter int          PORT_W  = 10,
    parameter int unsigned XA_BASE = 32'h600
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_we,
    input logic [AW-1:0]     req_addr,
    input logic [1:0]        req_size,
    input logic [31:0]       req_wdata,
    input logic              leg_stb,
    input logic [PORT_W-1:0] leg_port,
    input logic              ext_stb,
    input logic              ext_idx_load,
    input logic              big_endian_fb
);
    // R2: legacy and extension operations never overlap
    assert_one_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(leg_stb && ext_stb));

    // R2: consecutive byte operations walk upward one port at a time
    assert_port_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_stb && $past(leg_stb)) |-> (leg_port == $past(leg_port) + PORT_W'(1)));

    // R4: a data transfer always follows an index load
    assert_index_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_stb && !ext_idx_load) |-> $past(ext_stb && ext_idx_load));

    // R10: no new request is taken while a port operation runs
    assert_busy_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_stb || ext_stb) |-> !req_ready);

    // R6: the byte-order flag moves only after an accepted magic write
    assert_flag_magic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(big_endian_fb) |-> $past(req_valid && req_ready && req_we &&
            req_size == 2'd2 && req_addr == AW'(XA_BASE + 4) &&
            (req_wdata == MAGIC_BIG || req_wdata == MAGIC_LITTLE)));

endmodule

bind mmio_win mmio_win_chk #(.AW(AW), .PORT_W(PORT_W), .XA_BASE(XA_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .leg_stb(leg_stb), .leg_port(leg_port),
    .ext_stb(ext_stb), .ext_idx_load(ext_idx_load),
    .big_endian_fb(big_endian_fb)
);

// File: tb/tb_mmio_win.sv
module tb_mmio_win;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        leg_stb, leg_we;
    logic [9:0]  leg_port;
    logic [7:0]  leg_wdata, leg_rdata;
    logic        ext_stb, ext_idx_load, ext_we;
    logic [15:0] ext_wdata, ext_rdata;
    logic        big_endian_fb;
    logic [7:0]  rev_id;

    logic        nx_ready, nx_rsp_valid, nx_leg_stb, nx_leg_we;
    logic [31:0] nx_rsp_rdata;
    logic [9:0]  nx_leg_port;
    logic [7:0]  nx_leg_wdata, nx_rev;
    logic        nx_ext_stb, nx_ext_idx, nx_ext_we, nx_big;
    logic [15:0] nx_ext_wdata;

    always #4 clk = ~clk;

    mmio_win dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .leg_stb(leg_stb), .leg_we(leg_we), .leg_port(leg_port),
        .leg_wdata(leg_wdata), .leg_rdata(leg_rdata), .ext_stb(ext_stb),
        .ext_idx_load(ext_idx_load), .ext_we(ext_we), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .big_endian_fb(big_endian_fb), .rev_id(rev_id)
    );

    mmio_win #(.XA_ON(1'b0)) dut_nx (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(nx_ready),
        .req_we(req_we), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(nx_rsp_valid), .rsp_rdata(nx_rsp_rdata),
        .leg_stb(nx_leg_stb), .leg_we(nx_leg_we), .leg_port(nx_leg_port),
        .leg_wdata(nx_leg_wdata), .leg_rdata(8'h00), .ext_stb(nx_ext_stb),
        .ext_idx_load(nx_ext_idx), .ext_we(nx_ext_we), .ext_wdata(nx_ext_wdata),
        .ext_rdata(16'h0000), .big_endian_fb(nx_big), .rev_id(nx_rev)
    );

    // bench-side register models and operation logs
    logic [7:0]  lmem [32];
    logic [15:0] emem [16];
    logic [3:0]  eidx;
    int          nl, ne;
    logic [9:0]  lg_port [8];
    logic [7:0]  lg_data [8];
    logic        eg_idx  [8];
    logic [15:0] eg_data [8];

    assign leg_rdata = lmem[5'(leg_port - 10'h3C0)];
    assign ext_rdata = emem[eidx];

    always @(posedge clk) begin
        if (leg_stb) begin
            if (leg_we) lmem[5'(leg_port - 10'h3C0)] = leg_wdata;
            if (nl < 8) begin lg_port[nl] = leg_port; lg_data[nl] = leg_wdata; end
            nl++;
        end
        if (ext_stb) begin
            if (ext_idx_load) eidx = ext_wdata[3:0];
            else if (ext_we) emem[eidx] = ext_wdata;
            if (ne < 8) begin eg_idx[ne] = ext_idx_load; eg_data[ne] = ext_wdata; end
            ne++;
        end
    end

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [11:0] a, input logic [1:0] sz, input logic w,
                       input logic [31:0] wd, output logic [31:0] rd,
                       output logic [31:0] nxrd, output int lat, output int busy);
        @(negedge clk);
        nl = 0; ne = 0;
        req_addr = a; req_size = sz; req_we = w; req_wdata = wd; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; busy = 0;
        while (!rsp_valid && lat < 20) begin
            if (!req_ready) busy++;
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        nxrd = nx_rsp_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, nxrd, v, exp;
        int lat, busy;
        for (int i = 0; i < 32; i++) lmem[i] = 8'h00;
        for (int i = 0; i < 16; i++) emem[i] = 16'h0000;
        eidx = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready && !rsp_valid && !leg_stb && !ext_stb && !big_endian_fb,
            "R1 reset outputs", {27'd0, req_ready, rsp_valid, leg_stb, ext_stb, big_endian_fb},
            32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rev_id == 8'd2, "R1 rev enabled", 32'(rev_id), 32'd2);
        chk(nx_rev == 8'd1, "R1 rev disabled", 32'(nx_rev), 32'd1);

        // R2 R3 R8 R10: legacy sweep over all offsets and sizes
        for (int sz = 0; sz < 3; sz++) begin
            for (int o = 0; o < 32; o++) begin
                int n;
                n = 1 << sz;
                v = 32'h11223344 ^ (32'(o) * 32'h01030507) ^ (32'(sz) << 28);
                acc(12'(12'h400 + o), 2'(sz), 1'b1, v, rd, nxrd, lat, busy);
                if (o + n <= 32) begin
                    bit ok;
                    ok = (nl == n);
                    for (int k = 0; k < n && k < 8; k++) begin
                        if (lg_port[k] != 10'(10'h3C0 + o + k)) ok = 1'b0;
                        if (lg_data[k] != 8'(v >> (8 * k))) ok = 1'b0;
                    end
                    chk(ok, "R2 legacy write split", 32'(nl), 32'(n));
                    chk(busy == n, "R10 ready low while busy", 32'(busy), 32'(n));
                    acc(12'(12'h400 + o), 2'(sz), 1'b0, 32'h0, rd, nxrd, lat, busy);
                    exp = (n == 4) ? v : (v & ((32'd1 << (8 * n)) - 32'd1));
                    chk(rd == exp, "R3 legacy read assembly", rd, exp);
                    chk(lat == n + 1, "R3 legacy latency", 32'(lat), 32'(n + 1));
                end else begin
                    chk(nl == 0 && ne == 0 && lat == 1, "R8 straddling write ignored",
                        32'(nl), 32'd0);
                    acc(12'(12'h400 + o), 2'(sz), 1'b0, 32'h0, rd, nxrd, lat, busy);
                    chk(rd == 32'd0 && nl == 0 && busy == 0, "R8 straddling read zero",
                        rd, 32'd0);
                end
            end
        end

        // R4: extension bank, every index
        for (int i = 0; i < 11; i++) begin
            v = 32'hFFFF_A500 + 32'(i * 7);
            acc(12'(12'h500 + 2 * i), 2'd1, 1'b1, v, rd, nxrd, lat, busy);
            chk(ne == 2 && eg_idx[0] && eg_data[0] == 16'(i) && !eg_idx[1] &&
                eg_data[1] == v[15:0] && lat == 3, "R4 ext index then write",
                32'(eg_data[0]), 32'(i));
        end
        for (int i = 0; i < 11; i++) begin
            exp = 32'h0000_A500 + 32'(i * 7);
            acc(12'(12'h500 + 2 * i), 2'd1, 1'b0, 32'h0, rd, nxrd, lat, busy);
            chk(rd == exp && lat == 3, "R4 ext read even addr", rd, exp);
            acc(12'(12'h501 + 2 * i), 2'd2, 1'b0, 32'h0, rd, nxrd, lat, busy);
            chk(rd == exp, "R4 ext read odd addr", rd, exp);
        end
        acc(12'h516, 2'd1, 1'b1, 32'h1234, rd, nxrd, lat, busy);
        chk(ne == 0 && lat == 1, "R8 past ext bank no op", 32'(ne), 32'd0);
        acc(12'h516, 2'd1, 1'b0, 32'h0, rd, nxrd, lat, busy);
        chk(rd == 32'd0, "R8 past ext bank reads zero", rd, 32'd0);
        acc(12'h400, 2'd3, 1'b1, 32'hFF, rd, nxrd, lat, busy);
        chk(nl == 0 && lat == 1 && busy == 0, "R8 invalid size ignored", 32'(nl), 32'd0);

        // R5 R6 R7 R9: word region
        acc(12'h600, 2'd2, 1'b0, 32'h0, rd, nxrd, lat, busy);
        chk(rd == 32'd8 && lat == 1 && nl == 0 && ne == 0, "R5 size word", rd, 32'd8);
        chk(nxrd == 32'd0, "R8 disabled region size reads zero", nxrd, 32'd0);
        acc(12'h604, 2'd2, 1'b0, 32'h0, rd, nxrd, lat, busy);
        chk(rd == 32'h1E1E1E1E, "R6 little after reset", rd, 32'h1E1E1E1E);
        chk(nxrd == 32'd0, "R8 disabled region order reads zero", nxrd, 32'd0);
        acc(12'h604, 2'd2, 1'b1, 32'hBEBEBEBF, rd, nxrd, lat, busy);
        chk(!big_endian_fb, "R6 near-miss ignored", {31'd0, big_endian_fb}, 32'd0);
        acc(12'h604, 2'd2, 1'b1, 32'hBEBEBEBE, rd, nxrd, lat, busy);
        chk(big_endian_fb && lat == 1 && nl == 0, "R9 R6 set big", {31'd0, big_endian_fb}, 32'd1);
        chk(!nx_big, "R8 disabled region flag stays", {31'd0, nx_big}, 32'd0);
        acc(12'h604, 2'd2, 1'b0, 32'h0, rd, nxrd, lat, busy);
        chk(rd == 32'hBEBEBEBE, "R6 read big", rd, 32'hBEBEBEBE);
        acc(12'h604, 2'd2, 1'b1, 32'h12345678, rd, nxrd, lat, busy);
        chk(big_endian_fb, "R6 other value ignored", {31'd0, big_endian_fb}, 32'd1);
        acc(12'h604, 2'd1, 1'b1, 32'h1E1E1E1E, rd, nxrd, lat, busy);
        chk(big_endian_fb, "R7 half write ignored", {31'd0, big_endian_fb}, 32'd1);
        acc(12'h604, 2'd0, 1'b0, 32'h0, rd, nxrd, lat, busy);
        chk(rd == 32'd0, "R7 byte read zero", rd, 32'd0);
        acc(12'h602, 2'd2, 1'b0, 32'h0, rd, nxrd, lat, busy);
        chk(rd == 32'd0, "R7 unaligned read zero", rd, 32'd0);
        acc(12'h600, 2'd2, 1'b1, 32'h1E1E1E1E, rd, nxrd, lat, busy);
        chk(big_endian_fb, "R7 size word write ignored", {31'd0, big_endian_fb}, 32'd1);
        acc(12'h604, 2'd2, 1'b1, 32'h1E1E1E1E, rd, nxrd, lat, busy);
        chk(!big_endian_fb, "R6 clear to little", {31'd0, big_endian_fb}, 32'd0);
        acc(12'h604, 2'd2, 1'b0, 32'h0, rd, nxrd, lat, busy);
        chk(rd == 32'h1E1E1E1E, "R6 read little", rd, 32'h1E1E1E1E);

        // R8: far outside
        acc(12'hFFC, 2'd2, 1'b0, 32'h0, rd, nxrd, lat, busy);
        chk(rd == 32'd0 && lat == 1 && nl == 0 && ne == 0, "R8 unmapped read", rd, 32'd0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule